// File: doc/BRIEF.md
# Dual Mask Register Unit

This unit stores the two masks that a content-addressed lookup path uses to hide bits during a compare or to protect bits during a write. The first mask has a working (foreground) copy and a spare (background) copy. A single swap command exchanges the two copies in one clock, so a caller can keep a second context loaded and switch to it at once. The second mask has only one copy. A command moves it one bit toward the top or toward the bottom.

Software loads the masks one segment at a time through a narrow write port. Each write can carry its own per-bit protect pattern, and a protected bit keeps its old value. Any copy can be read back as a whole word. A separate select input picks which mask drives the active-mask output. That output reflects the foreground copy of the first mask or the second mask.

Top module: `dual_mask_unit`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, the foreground copy, the background copy and the second mask all become zero.
- R2: A write with `wr_en` high and `cmd` = 0 sets segment `wr_seg` of the copy chosen by `wr_dest`. Segment k covers bits k*SEG_W+SEG_W-1 down to k*SEG_W. The `wr_dest` codes are 0 for the foreground copy, 1 for the background copy and 2 for the second mask. Code 3 changes nothing.
- R3: During a write, each bit set in `wr_keep` leaves the matching bit of the target segment unchanged. Bits outside the addressed segment never change.
- R4: `cmd` = 1 exchanges the foreground and background copies in a single clock. The second mask is left as it is.
- R5: `cmd` = 2 moves every bit of the second mask one place toward the MSB. Bit 0 becomes 0 and the old MSB is dropped.
- R6: `cmd` = 3 moves every bit of the second mask one place toward bit 0. The MSB becomes 0 and the old bit 0 is dropped.
- R7: When `cmd` is nonzero, a write presented in the same cycle is ignored.
- R8: `active_mask` equals the foreground copy when `act_sel` = 0 and the second mask when `act_sel` = 1. It changes with no clock delay.
- R9: `rd_data` returns the copy chosen by `rd_sel`, using the same codes as `wr_dest`, and returns zero for code 3. It changes with no clock delay.
- R10: In a cycle with no write and `cmd` = 0, all three copies keep their values. A shift never changes the first mask's copies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Segment write request |
| wr_dest | input | 2 | Write target: 0 foreground, 1 background, 2 second mask, 3 none |
| wr_seg | input | SEG_IDX_W | Segment index of the write |
| wr_data | input | SEG_W | Segment write data |
| wr_keep | input | SEG_W | Per-bit protect: 1 keeps the old bit |
| cmd | input | 2 | 0 idle, 1 swap, 2 shift up, 3 shift down |
| act_sel | input | 1 | Active mask select: 0 foreground, 1 second mask |
| active_mask | output | SEG_W*NUM_SEGS | Mask applied to the current operation |
| rd_sel | input | 2 | Read select, same codes as wr_dest |
| rd_data | output | SEG_W*NUM_SEGS | Whole-word readback |

## Verification
The bench builds the unit with its default values, SEG_W = 16 and NUM_SEGS = 4. This gives a 64-bit word in four segments. With that word, a shift can carry bits across every segment boundary and push a bit off either end of the word. Segment writes can land at the lowest and highest positions with partial protect patterns. Runs of random commands mix swaps, shifts in both directions and blocked writes, and all three copies are read back after every clock.

// File: rtl/dual_mask_unit.sv
module dual_mask_unit #(
  parameter int SEG_W = 16,
  parameter int NUM_SEGS = 4,
  localparam int W = SEG_W * NUM_SEGS,
  localparam int SEG_IDX_W = (NUM_SEGS > 1) ? $clog2(NUM_SEGS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [1:0]           wr_dest,
  input  logic [SEG_IDX_W-1:0] wr_seg,
  input  logic [SEG_W-1:0]     wr_data,
  input  logic [SEG_W-1:0]     wr_keep,
  input  logic [1:0]           cmd,
  input  logic                 act_sel,
  output logic [W-1:0]         active_mask,
  input  logic [1:0]           rd_sel,
  output logic [W-1:0]         rd_data
);
  localparam logic [1:0] CMD_IDLE = 2'd0;
  localparam logic [1:0] CMD_SWAP = 2'd1;
  localparam logic [1:0] CMD_SHL  = 2'd2;
  localparam logic [1:0] CMD_SHR  = 2'd3;

  logic [W-1:0] m1_fg, m1_bg, m2;
  logic [W-1:0] upd_bits, wdata_w;
  logic         do_wr;
  int           shamt;

  assign shamt    = int'(wr_seg) * SEG_W;
  assign upd_bits = {{(W-SEG_W){1'b0}}, ~wr_keep} << shamt;
  assign wdata_w  = {{(W-SEG_W){1'b0}}, wr_data} << shamt;
  assign do_wr    = wr_en && (cmd == CMD_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m1_fg <= '0;
      m1_bg <= '0;
      m2    <= '0;
    end else begin
      case (cmd)
        CMD_SWAP: begin
          m1_fg <= m1_bg;
          m1_bg <= m1_fg;
        end
        CMD_SHL: m2 <= {m2[W-2:0], 1'b0};
        CMD_SHR: m2 <= {1'b0, m2[W-1:1]};
        default: if (do_wr) begin
          case (wr_dest)
            2'd0: m1_fg <= (m1_fg & ~upd_bits) | (wdata_w & upd_bits);
            2'd1: m1_bg <= (m1_bg & ~upd_bits) | (wdata_w & upd_bits);
            2'd2: m2    <= (m2 & ~upd_bits) | (wdata_w & upd_bits);
            default: ;
          endcase
        end
      endcase
    end
  end

  assign active_mask = act_sel ? m2 : m1_fg;

  always_comb begin
    case (rd_sel)
      2'd0:    rd_data = m1_fg;
      2'd1:    rd_data = m1_bg;
      2'd2:    rd_data = m2;
      default: rd_data = '0;
    endcase
  end

  p_swap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cmd) == CMD_SWAP) |->
      (m1_fg == $past(m1_bg) && m1_bg == $past(m1_fg) && $stable(m2)));

  p_shl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cmd) == CMD_SHL) |->
      (m2[0] == 1'b0 && m2[W-1:1] == $past(m2[W-2:0])));

  p_shr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cmd) == CMD_SHR) |->
      (m2[W-1] == 1'b0 && m2[W-2:0] == $past(m2[W-1:1])));

  p_shift_keeps_m1_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cmd[1])) |-> ($stable(m1_fg) && $stable(m1_bg)));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cmd) == CMD_IDLE && !$past(wr_en)) |->
      ($stable(m1_fg) && $stable(m1_bg) && $stable(m2)));

  p_seg_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cmd) == CMD_IDLE && $past(wr_en)) |->
      ((((m1_fg ^ $past(m1_fg)) | (m1_bg ^ $past(m1_bg)) | (m2 ^ $past(m2)))
        & ~$past(upd_bits)) == '0));
endmodule

// File: tb/tb_dual_mask_unit.sv
`timescale 1ns/10ps
module tb_dual_mask_unit;
  localparam int SEG_W = 16;
  localparam int NUM_SEGS = 4;
  localparam int W = SEG_W * NUM_SEGS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_dest = '0;
  logic [1:0] wr_seg = '0;
  logic [SEG_W-1:0] wr_data = '0, wr_keep = '0;
  logic [1:0] cmd = '0;
  logic act_sel = 1'b0;
  logic [1:0] rd_sel = '0;
  logic [W-1:0] active_mask, rd_data;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  logic [W-1:0] ref_m [3];

  always #2.5 clk = ~clk;

  dual_mask_unit #(.SEG_W(SEG_W), .NUM_SEGS(NUM_SEGS)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_dest(wr_dest), .wr_seg(wr_seg),
    .wr_data(wr_data), .wr_keep(wr_keep), .cmd(cmd), .act_sel(act_sel),
    .active_mask(active_mask), .rd_sel(rd_sel), .rd_data(rd_data));

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) ref_m[i] = '0;
    end else if (cmd == 2'd1) begin
      logic [W-1:0] t;
      t = ref_m[0]; ref_m[0] = ref_m[1]; ref_m[1] = t;
    end else if (cmd == 2'd2) begin
      ref_m[2] = ref_m[2] * 2;
    end else if (cmd == 2'd3) begin
      ref_m[2] = ref_m[2] / 2;
    end else if (wr_en && wr_dest != 2'd3) begin
      for (int b = 0; b < SEG_W; b++)
        if (!wr_keep[b]) ref_m[wr_dest][int'(wr_seg) * SEG_W + b] = wr_data[b];
    end
  end

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    for (int s = 0; s < 4; s++) begin
      rd_sel = 2'(s);
      #0.1;
      chk(req, rd_data, (s < 3) ? ref_m[s] : '0);
    end
    act_sel = 1'b0; #0.1; chk({req, "/R8"}, active_mask, ref_m[0]);
    act_sel = 1'b1; #0.1; chk({req, "/R8"}, active_mask, ref_m[2]);
  endtask

  task automatic step(string req, bit we, logic [1:0] d, logic [1:0] sg,
                      logic [SEG_W-1:0] dat, logic [SEG_W-1:0] kp, logic [1:0] c);
    wr_en = we; wr_dest = d; wr_seg = sg; wr_data = dat; wr_keep = kp; cmd = c;
    @(negedge clk);
    wr_en = 1'b0; cmd = 2'd0;
    check_all(req);
  endtask

  initial begin
    #(5.0 * 20000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    step("R2", 1, 2'd0, 2'd0, 16'hA5A5, 16'h0000, 2'd0);
    step("R2", 1, 2'd0, 2'd3, 16'h8001, 16'h0000, 2'd0);
    step("R2", 1, 2'd1, 2'd1, 16'h1234, 16'h0000, 2'd0);
    step("R2", 1, 2'd2, 2'd3, 16'hC000, 16'h0000, 2'd0);
    step("R2", 1, 2'd3, 2'd2, 16'hFFFF, 16'h0000, 2'd0);
    step("R3", 1, 2'd0, 2'd0, 16'h0000, 16'hFF00, 2'd0);
    step("R3", 1, 2'd2, 2'd0, 16'hFFFF, 16'h0F0F, 2'd0);
    step("R4", 0, 2'd0, 2'd0, 16'h0000, 16'h0000, 2'd1);
    step("R4", 0, 2'd0, 2'd0, 16'h0000, 16'h0000, 2'd1);
    step("R5", 0, 2'd0, 2'd0, 16'h0000, 16'h0000, 2'd2);
    step("R5", 0, 2'd0, 2'd0, 16'h0000, 16'h0000, 2'd2);
    step("R6", 0, 2'd0, 2'd0, 16'h0000, 16'h0000, 2'd3);
    step("R6", 1, 2'd2, 2'd0, 16'h0001, 16'h0000, 2'd0);
    step("R6", 0, 2'd0, 2'd0, 16'h0000, 16'h0000, 2'd3);
    step("R7", 1, 2'd0, 2'd1, 16'hFFFF, 16'h0000, 2'd2);
    step("R7", 1, 2'd2, 2'd1, 16'hFFFF, 16'h0000, 2'd1);
    step("R10", 0, 2'd0, 2'd0, 16'hFFFF, 16'h0000, 2'd0);
    step("R9", 0, 2'd3, 2'd0, 16'h0000, 16'h0000, 2'd0);
    for (int n = 0; n < 400; n++)
      step("R10", 1'($urandom), 2'($urandom), 2'($urandom), 16'($urandom),
           16'($urandom), 2'($urandom));
    rst_n = 1'b0;
    @(negedge clk);
    check_all("R1");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule